// File: doc/BRIEF.md
# Depth-Cascade Token Controller

This block holds the control logic for a ring of FIFO slices. The slices share one write strobe, one read strobe and one data bus, and together they act as one deeper queue. Two tokens travel around the ring. The slice that holds the write token accepts writes. The slice that holds the read token supplies read data. When a slice writes its last physical slot, it passes the write token to the next slice. When it reads its last physical slot, it passes the read token to the next slice. Each slice is given a small word store, a write pointer and a read pointer, so that its occupancy (write pointer minus read pointer) and its head word can be observed.

Each slice takes its role from two configuration levels sampled while reset is high. The roles are ROLE_SOLO, ROLE_LEAD and ROLE_FOLLOW. Each slice also runs two token state machines, one for the write token and one for the read token. Both have two states, TK_IDLE and TK_HOLD, and two transitions:
- TK_IDLE to TK_HOLD, taken on a pass pulse from the previous slice.
- TK_HOLD to TK_IDLE, taken on the slice's own pass pulse.

A solo slice stays in TK_HOLD and never passes. The write pass and the read pass are separate one-cycle signals, so both can fire in the same cycle. In solo mode every slice holds both tokens and behaves as a plain FIFO. A solo FIFO adds a half-full flag and a retransmit command that rewinds the read pointer to slot 0.

Top module: `cascade_token_ring`

## Requirements
- R1: While `rst` is high, each slice samples its role. If `ring_link` is 0 the slice is solo. If `ring_link` is 1 and its `lead_n` bit is 0 it is the lead. If `ring_link` is 1 and its `lead_n` bit is 1 it is a follower.
- R2: After reset, the lead slice holds both tokens and followers hold none. In solo mode every bit of `wr_tok` and `rd_tok` is 1. Bit i of `wr_tok` and `rd_tok` belongs to slice i.
- R3: In ring mode, an accepted write into the last physical slot of the write-token holder moves the write token to slice (i+1) mod N at the same clock edge.
- R4: In ring mode, an accepted read from the last physical slot of the read-token holder moves the read token to slice (i+1) mod N at the same clock edge.
- R5: In ring mode, at most one slice holds each token. A slice without the write token ignores `wr`, and a slice without the read token ignores `rd`. The words therefore come out in the order they were written, across slices.
- R6: `dout` is the OR of all slice outputs. A slice that does not hold the read token, or that holds it with no unread word, drives zero. `dout` shows the oldest unread word without waiting for a read strobe.
- R7: `full` is the OR of the per-slice full flags. A slice's full flag is raised when it holds the write token and all DEPTH of its slots are unread.
- R8: `empty` is the OR of the per-slice empty flags. A slice's empty flag is raised when it holds the read token and has no unread word.
- R9: In solo mode, `half_full` is 1 when the occupancy exceeds DEPTH/2. In ring mode it is always 0.
- R10: In solo mode, `rt` with `wr` and `rd` both low sets the read pointer to slot 0 and leaves the write pointer unchanged. In ring mode, `rt` has no effect.
- R11: Changes on `ring_link` and `lead_n` while `rst` is low have no effect on roles or tokens.
- R12: A write while `full` is 1 is dropped. A read while `empty` is 1 is dropped. A slice never holds more than DEPTH unread words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; roles are sampled while it is high |
| ring_link | input | 1 | 1: slices are linked in a ring; 0: expansion input tied low, solo mode |
| lead_n | input | N | Per-slice lead select, active low |
| wr | input | 1 | Shared write strobe, one word per cycle |
| rd | input | 1 | Shared read strobe, one word per cycle |
| rt | input | 1 | Retransmit, used in solo mode only |
| din | input | W | Shared write data |
| dout | output | W | OR of the slice head words |
| full | output | 1 | Composite full flag |
| empty | output | 1 | Composite empty flag |
| half_full | output | 1 | More than half full, solo mode only |
| wr_tok | output | N | Per-slice write enable (write token held) |
| rd_tok | output | N | Per-slice read enable (read token held) |

## Verification
The single-token assertions assume that ring mode is configured with exactly one `lead_n` bit low and at least two slices. The bench resets the ring only with configurations of that kind. The retransmit rules assume that `rt` comes only with `wr` and `rd` low, and that the write pointer has not wrapped since reset. The bench therefore issues retransmit in solo mode only, after fewer than 2·DEPTH writes. It also drives `rt` in ring mode, where it must be ignored. All strobes change on the falling edge, and the bench checks the outputs against a behavioural queue model after every rising edge.

// File: rtl/cascade_pkg.sv
package cascade_pkg;

    typedef enum logic [1:0] {
        ROLE_SOLO   = 2'd0,
        ROLE_LEAD   = 2'd1,
        ROLE_FOLLOW = 2'd2
    } role_t;

    typedef enum logic {
        TK_IDLE = 1'b0,
        TK_HOLD = 1'b1
    } tok_t;

endpackage

// File: rtl/ring_slice.sv
module ring_slice
    import cascade_pkg::*;
#(
    parameter int W     = 9,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cfg_link,
    input  logic         cfg_lead_n,
    input  logic         wr,
    input  logic         rd,
    input  logic         rt,
    input  logic [W-1:0] din,
    input  logic         wpass_in,
    input  logic         rpass_in,
    output logic         wpass_out,
    output logic         rpass_out,
    output logic         wtok,
    output logic         rtok,
    output logic         is_solo,
    output logic [W-1:0] dout,
    output logic         full_f,
    output logic         empty_f,
    output logic         half_f
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;
    localparam logic [CW-1:0] CAP  = CW'(DEPTH);
    localparam logic [CW-1:0] HALF = CW'(DEPTH / 2);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    role_t role_q, role_rst;
    tok_t  wst_q, wst_d, rdst_q, rdst_d;
    logic [CW-1:0] wptr_q, rptr_q, cnt;
    logic [W-1:0]  mem [DEPTH];
    logic wr_ok, rd_ok, rt_ok, wpass, rpass;

    // role decode from the levels present during reset
    always_comb begin
        if (!cfg_link)        role_rst = ROLE_SOLO;
        else if (!cfg_lead_n) role_rst = ROLE_LEAD;
        else                  role_rst = ROLE_FOLLOW;
    end

    assign cnt   = wptr_q - rptr_q;
    assign wr_ok = (wst_q == TK_HOLD) && wr && (cnt != CAP);
    assign rd_ok = (rdst_q == TK_HOLD) && rd && (cnt != '0);
    assign rt_ok = (role_q == ROLE_SOLO) && rt && !wr && !rd;
    assign wpass = (role_q != ROLE_SOLO) && wr_ok && (wptr_q[AW-1:0] == LAST);
    assign rpass = (role_q != ROLE_SOLO) && rd_ok && (rptr_q[AW-1:0] == LAST);

    // write-token next state
    always_comb begin
        wst_d = wst_q;
        unique case (wst_q)
            TK_IDLE: if (wpass_in) wst_d = TK_HOLD;
            TK_HOLD: if (wpass)    wst_d = TK_IDLE;
            default: wst_d = TK_IDLE;
        endcase
    end

    // read-token next state
    always_comb begin
        rdst_d = rdst_q;
        unique case (rdst_q)
            TK_IDLE: if (rpass_in) rdst_d = TK_HOLD;
            TK_HOLD: if (rpass)    rdst_d = TK_IDLE;
            default: rdst_d = TK_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            role_q <= role_rst;
            wst_q  <= (role_rst == ROLE_FOLLOW) ? TK_IDLE : TK_HOLD;
            rdst_q <= (role_rst == ROLE_FOLLOW) ? TK_IDLE : TK_HOLD;
            wptr_q <= '0;
            rptr_q <= '0;
        end else begin
            wst_q  <= wst_d;
            rdst_q <= rdst_d;
            if (wr_ok) wptr_q <= wptr_q + 1'b1;
            if (rt_ok)      rptr_q <= '0;
            else if (rd_ok) rptr_q <= rptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wptr_q[AW-1:0]] <= din;
    end

    // outputs
    always_comb begin
        wpass_out = wpass;
        rpass_out = rpass;
        wtok      = (wst_q == TK_HOLD);
        rtok      = (rdst_q == TK_HOLD);
        is_solo   = (role_q == ROLE_SOLO);
        full_f    = (wst_q == TK_HOLD) && (cnt == CAP);
        empty_f   = (rdst_q == TK_HOLD) && (cnt == '0);
        half_f    = (role_q == ROLE_SOLO) && (cnt > HALF);
        dout      = ((rdst_q == TK_HOLD) && (cnt != '0)) ? mem[rptr_q[AW-1:0]] : '0;
    end

    assert_cnt_bound_R12: assert property (@(posedge clk) disable iff (rst)
        cnt <= CAP);
    assert_wpass_drop_R3: assert property (@(posedge clk) disable iff (rst)
        wpass |=> (wst_q == TK_IDLE));
    assert_rpass_drop_R4: assert property (@(posedge clk) disable iff (rst)
        rpass |=> (rdst_q == TK_IDLE));
    assert_dout_idle_R6: assert property (@(posedge clk) disable iff (rst)
        (rdst_q == TK_IDLE) |-> (dout == '0));
    assert_hf_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (role_q != ROLE_SOLO) |-> !half_f);
    assert_rt_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        ((role_q != ROLE_SOLO) && rt && !rd) |=> (rptr_q == $past(rptr_q)));
endmodule

// File: rtl/ring_merge.sv
module ring_merge #(
    parameter int N = 3,
    parameter int W = 9
) (
    input  logic [N-1:0][W-1:0] slice_dout,
    input  logic [N-1:0]        slice_full,
    input  logic [N-1:0]        slice_empty,
    input  logic [N-1:0]        slice_half,
    output logic [W-1:0]        dout,
    output logic                full,
    output logic                empty,
    output logic                half_full
);
    always_comb begin
        dout = '0;
        for (int i = 0; i < N; i++) dout = dout | slice_dout[i];
    end
    assign full      = |slice_full;
    assign empty     = |slice_empty;
    assign half_full = |slice_half;
endmodule

// File: rtl/cascade_token_ring.sv
module cascade_token_ring #(
    parameter int N     = 3,
    parameter int W     = 9,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ring_link,
    input  logic [N-1:0] lead_n,
    input  logic         wr,
    input  logic         rd,
    input  logic         rt,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty,
    output logic         half_full,
    output logic [N-1:0] wr_tok,
    output logic [N-1:0] rd_tok
);
    logic [N-1:0]        wpass, rpass, solo, s_full, s_empty, s_half;
    logic [N-1:0][W-1:0] s_dout;

    for (genvar i = 0; i < N; i++) begin : g_slice
        localparam int PREV = (i + N - 1) % N;
        ring_slice #(.W(W), .DEPTH(DEPTH)) slice_i (
            .clk       (clk),
            .rst       (rst),
            .cfg_link  (ring_link),
            .cfg_lead_n(lead_n[i]),
            .wr        (wr),
            .rd        (rd),
            .rt        (rt),
            .din       (din),
            .wpass_in  (wpass[PREV]),
            .rpass_in  (rpass[PREV]),
            .wpass_out (wpass[i]),
            .rpass_out (rpass[i]),
            .wtok      (wr_tok[i]),
            .rtok      (rd_tok[i]),
            .is_solo   (solo[i]),
            .dout      (s_dout[i]),
            .full_f    (s_full[i]),
            .empty_f   (s_empty[i]),
            .half_f    (s_half[i])
        );
    end

    ring_merge #(.N(N), .W(W)) merge_i (
        .slice_dout (s_dout),
        .slice_full (s_full),
        .slice_empty(s_empty),
        .slice_half (s_half),
        .dout       (dout),
        .full       (full),
        .empty      (empty),
        .half_full  (half_full)
    );

    assert_one_wtok_R5: assert property (@(posedge clk) disable iff (rst)
        !(|solo) |-> $onehot0(wr_tok));
    assert_one_rtok_R5: assert property (@(posedge clk) disable iff (rst)
        !(|solo) |-> $onehot0(rd_tok));
    assert_tok_handoff_R3: assert property (@(posedge clk) disable iff (rst)
        (|wpass) |=> ($countones(wr_tok) == 1));
endmodule

// File: tb/cascade_token_ring_tb.sv
module cascade_token_ring_tb_top;
    localparam int N = 3;
    localparam int W = 9;
    localparam int D = 4;
    localparam int CAP = N * D;
    localparam int CLK_P = 10;

    logic clk = 0;
    logic rst = 1;
    logic ring_link = 1;
    logic [N-1:0] lead_n = '1;
    logic wr = 0, rd = 0, rt = 0;
    logic [W-1:0] din = '0;
    logic [W-1:0] dout;
    logic full, empty, half_full;
    logic [N-1:0] wr_tok, rd_tok;

    cascade_token_ring #(.N(N), .W(W), .DEPTH(D)) dut_i (
        .clk(clk), .rst(rst), .ring_link(ring_link), .lead_n(lead_n),
        .wr(wr), .rd(rd), .rt(rt), .din(din), .dout(dout), .full(full),
        .empty(empty), .half_full(half_full), .wr_tok(wr_tok), .rd_tok(rd_tok));

    always #(CLK_P/2) clk = ~clk;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // behavioural model
    bit solo_m;
    int wpos, rpos, cnt_m;
    logic [W-1:0] marr [CAP];

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_dout();
        if (cnt_m == 0) return 0;
        return solo_m ? int'(marr[rpos % D]) : int'(marr[rpos]);
    endfunction
    function automatic int exp_wtok();
        return solo_m ? (1 << N) - 1 : 1 << (wpos / D);
    endfunction
    function automatic int exp_rtok();
        return solo_m ? (1 << N) - 1 : 1 << (rpos / D);
    endfunction

    task automatic compare_all();
        int lim;
        lim = solo_m ? D : CAP;
        chk("R6 dout", int'(dout), exp_dout());
        chk("R7 full", int'(full), int'(cnt_m == lim));
        chk("R8 empty", int'(empty), int'(cnt_m == 0));
        chk("R9 half_full", int'(half_full), int'(solo_m && cnt_m > D/2));
        chk("R3 wr_tok", int'(wr_tok), exp_wtok());
        chk("R4 rd_tok", int'(rd_tok), exp_rtok());
    endtask

    task automatic model_step(input bit w, input bit r, input bit t, input logic [W-1:0] d);
        bit dw, dr;
        if (solo_m) begin
            dw = w && cnt_m < D;
            dr = r && cnt_m > 0;
            if (dw) begin marr[wpos % D] = d; wpos = (wpos + 1) % (2*D); end
            if (t && !w && !r) rpos = 0;
            else if (dr) rpos = (rpos + 1) % (2*D);
            cnt_m = (wpos - rpos + 2*D) % (2*D);
        end else begin
            dw = w && cnt_m < CAP;
            dr = r && cnt_m > 0;
            if (dw) begin marr[wpos] = d; wpos = (wpos + 1) % CAP; end
            if (dr) rpos = (rpos + 1) % CAP;
            cnt_m = cnt_m + int'(dw) - int'(dr);
        end
    endtask

    task automatic cyc(input bit w, input bit r, input bit t, input logic [W-1:0] d);
        wr = w; rd = r; rt = t; din = d;
        @(posedge clk);
        model_step(w, r, t, d);
        @(negedge clk);
        compare_all();
    endtask

    task automatic do_reset(input bit link, input logic [N-1:0] ln);
        @(negedge clk);
        rst = 1; ring_link = link; lead_n = ln; wr = 0; rd = 0; rt = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 0;
        solo_m = !link;
        wpos = 0;
        for (int i = 0; i < N; i++) if (link && !ln[i]) wpos = i * D;
        rpos = wpos; cnt_m = 0;
        compare_all();
    endtask

    initial begin : watchdog
        #(CLK_P * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [N-1:0] tok_before;
        // ring mode, slice 0 leads (R1, R2)
        do_reset(1'b1, 3'b110);
        chk("R2 lead wr_tok", int'(wr_tok), 1);
        chk("R1 lead rd_tok", int'(rd_tok), 1);
        chk("R8 empty after reset", int'(empty), 1);
        // fill the whole ring; tokens cross slices (R3, R5)
        for (int i = 0; i < CAP; i++) cyc(1, 0, 0, W'(i + 16));
        chk("R7 full at capacity", int'(full), 1);
        chk("R5 single write token", $countones(wr_tok), 1);
        // write while full is dropped (R12)
        cyc(1, 0, 0, 9'h1AA);
        chk("R12 dout unchanged", int'(dout), 16);
        // config change outside reset is ignored (R11); rt ignored in ring mode (R10)
        tok_before = rd_tok;
        lead_n = 3'b011; ring_link = 0;
        cyc(0, 0, 1, '0);
        chk("R11 tokens kept", int'(rd_tok), int'(tok_before));
        chk("R10 rt ignored in ring", int'(dout), 16);
        // drain with a simultaneous write/read mix (R4, R6)
        for (int i = 0; i < CAP + 2; i++) cyc(1'(i % 3 == 0), 1, 0, W'(i + 100));
        for (int i = 0; i < 6; i++) cyc(0, 1, 0, '0);
        chk("R12 empty read dropped", int'(empty), 1);
        chk("R6 dout zero when empty", int'(dout), 0);
        // random ring traffic
        for (int i = 0; i < 600; i++)
            cyc(1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 4 == 0), W'($urandom));
        // ring mode, slice 2 leads
        do_reset(1'b1, 3'b011);
        chk("R2 lead slice2", int'(wr_tok), 4);
        for (int i = 0; i < 600; i++)
            cyc(1'($urandom % 3 != 0), 1'($urandom % 2), 1'b0, W'($urandom));
        // solo mode (R1, R9, R10)
        do_reset(1'b0, 3'b111);
        chk("R1 solo tokens", int'(wr_tok), (1 << N) - 1);
        for (int i = 0; i < 3; i++) cyc(1, 0, 0, W'(i + 50));
        chk("R9 half_full above half", int'(half_full), 1);
        cyc(1, 0, 0, W'(53));
        chk("R7 solo full", int'(full), 1);
        cyc(0, 1, 0, '0);
        cyc(0, 1, 0, '0);
        chk("R9 half_full at half", int'(half_full), 0);
        cyc(0, 0, 1, '0);
        chk("R10 rewind head", int'(dout), 50);
        chk("R10 rewind full", int'(full), 1);
        for (int i = 0; i < 400; i++)
            cyc(1'($urandom % 2), 1'($urandom % 2), 1'b0, W'($urandom));
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule